// File: doc/BRIEF.md
# Chained Byte-Wide Configuration Receiver

This block is the receiving end of a byte-wide configuration port. A host drives bytes into it on an external configuration clock. It runs as a slave and does nothing until an init line is released. At that moment it samples a 3-bit mode input, and it arms only when that input holds the slave-parallel code. Once armed, it takes a byte on each clock edge where the chip select and the write strobe are both low. Bytes pass through a small staging buffer into the payload memory. A busy flag holds the host back whenever the staging buffer cannot take more.

When the last byte of its own payload lands in memory, the block raises done. In the same cycle it pulls its active-low chip-select output low, which hands the bus to the next device in a chain. The block can optionally stay alive after that point. With the keep-alive input set, the host can stream the stored payload back out. With keep-alive clear, the block ignores the bus once it is done. An active-low program input returns the whole block to its unconfigured state.

Top module: `cfg_byte_port`

## Requirements
- R1: While prog_n is low, and on the first clock after it rises, the outputs are busy=0, done=0, cs_out_n=1, dout_vld=0 and dout=0, and the port is unarmed.
- R2: mode_sel is sampled only at the first clock edge where init_rel is seen high after being low. The port arms only if the sample equals 3'b110 (bit2=1, bit1=1, bit0=0). A change of mode_sel with no new init_rel rise has no effect.
- R3: While the port is unarmed, writes are ignored: busy stays 0 and done never rises.
- R4: A byte on din is taken at a rising cclk edge only when all of the following hold in that cycle: the port is armed, done=0, cs_n=0, wr_n=0 and busy=0. A cycle with cs_n=1 or wr_n=1 stores nothing.
- R5: busy is 1 while the port is armed, not done, and either the staging buffer holds BUF_DEPTH bytes or all PAYLOAD_BYTES bytes have been taken. A byte presented while busy=1 is not consumed, and the host must hold it.
- R6: The staging buffer moves at most one byte every DRAIN_DIV clocks into the payload memory, in arrival order. The divider runs only while the port is armed.
- R7: done rises and cs_out_n falls at the clock edge that writes the PAYLOAD_BYTES-th byte into memory. Both then hold until prog_n goes low.
- R8: With keep_alive=0, the port ignores all bus activity after done: busy=0 and dout_vld=0.
- R9: With keep_alive=1 and done=1, each clock with cs_n=0 and wr_n=1 registers the next stored byte on dout with dout_vld=1. Readback starts at address 0 and wraps after the last byte. Any cycle that is not a read returns the address to 0 and drives dout=0.
- R10: Writes after done do not change the stored payload, even with keep_alive=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock from the host |
| prog_n | input | 1 | Active-low asynchronous program reset |
| init_rel | input | 1 | Init release; its rise samples mode_sel |
| mode_sel | input | 3 | Mode code; 3'b110 selects this port |
| keep_alive | input | 1 | Keep the port active after done for readback |
| cs_n | input | 1 | Active-low chip select from the host or previous device |
| wr_n | input | 1 | Direction: 0 = write, 1 = read |
| din | input | W | Write data byte |
| busy | output | 1 | Host must hold its byte while high |
| done | output | 1 | Own payload fully stored |
| cs_out_n | output | 1 | Active-low select to the next device, always driven |
| dout | output | W | Readback data, registered |
| dout_vld | output | 1 | dout carries a readback byte |

## Verification
Internal state faults become visible at the ports within a few clocks. A staging count that is off by one shows as busy rising one cycle early or late. A drain divider set wrong moves the cycle in which done rises. A wrong write or read pointer first shows during readback, as a byte out of order or a wrap to the wrong address. A mode latch that re-samples without a new init rise shows as writes taken, or lost, in cycles where the port should be idle. A reference model is compared against every clock, so a fault is reported in the first cycle it reaches busy, done, cs_out_n or dout.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam logic [2:0] SLAVE_PAR_CODE = 3'b110;

  // Arm decision for a sampled mode code.
  function automatic logic mode_accepts(input logic [2:0] code);
    return code == SLAVE_PAR_CODE;
  endfunction

  // Modulo increment used for pointers and the drain divider.
  function automatic int wrap_inc(input int v, input int lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/cfg_mode_latch.sv
module cfg_mode_latch
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_rel,
  input  logic [2:0] mode_sel,
  output logic       armed,
  output logic       init_rise
);

  logic init_q;

  assign init_rise = init_rel & ~init_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      init_q <= init_rel;
      if (init_rise) armed <= mode_accepts(mode_sel);
    end
  end

endmodule

// File: rtl/cfg_byte_fifo.sv
module cfg_byte_fifo
  import cfg_port_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = slots[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= PW'(wrap_inc(int'(wp), DEPTH));
      if (pop)  rp <= PW'(wrap_inc(int'(rp), DEPTH));
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= wdata;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6

endmodule

// File: rtl/cfg_payload_store.sv
module cfg_payload_store
  import cfg_port_pkg::*;
#(
  parameter int P = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         st_en,
  input  logic [W-1:0] st_data,
  input  logic         rd_req,
  output logic         done,
  output logic         last_store,
  output logic [W-1:0] dout,
  output logic         dout_vld
);

  localparam int SW = $clog2(P + 1);
  localparam int RW = (P > 1) ? $clog2(P) : 1;

  logic [W-1:0]  mem [P];
  logic [SW-1:0] st_cnt;
  logic [RW-1:0] rd_ptr;

  assign last_store = st_en & (st_cnt == SW'(P - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_cnt   <= '0;
      done     <= 1'b0;
      rd_ptr   <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      if (st_en) st_cnt <= st_cnt + 1'b1;
      if (last_store) done <= 1'b1;
      if (rd_req) begin
        dout     <= mem[rd_ptr];
        dout_vld <= 1'b1;
        rd_ptr   <= RW'(wrap_inc(int'(rd_ptr), P));
      end else begin
        dout     <= '0;
        dout_vld <= 1'b0;
        rd_ptr   <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st_en) mem[st_cnt[RW-1:0]] <= st_data;
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R7
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_store)); // R7
  AST_NO_STORE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !st_en); // R10
  AST_RB_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> $past(done)); // R9

endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
  import cfg_port_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 16,
  parameter int DRAIN_DIV     = 2,
  parameter int BUF_DEPTH     = 4,
  parameter int W             = 8
) (
  input  logic         cclk,
  input  logic         prog_n,
  input  logic         init_rel,
  input  logic [2:0]   mode_sel,
  input  logic         keep_alive,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic         done,
  output logic         cs_out_n,
  output logic [W-1:0] dout,
  output logic         dout_vld
);

  localparam int AW = $clog2(PAYLOAD_BYTES + 1);
  localparam int DW = (DRAIN_DIV > 1) ? $clog2(DRAIN_DIV) : 1;

  // Named internal events
  logic          armed, init_rise;
  logic          buf_full, buf_empty;
  logic [W-1:0]  buf_head;
  logic          all_taken, wr_accept, drain_tick, drain_pop, rd_req;
  logic          last_store;
  logic [AW-1:0] acc_cnt;
  logic [DW-1:0] div_cnt;

  cfg_mode_latch u_mode (
    .clk       (cclk),
    .rst_n     (prog_n),
    .init_rel  (init_rel),
    .mode_sel  (mode_sel),
    .armed     (armed),
    .init_rise (init_rise)
  );

  assign all_taken  = (acc_cnt == AW'(PAYLOAD_BYTES));
  assign busy       = armed & ~done & (buf_full | all_taken);
  assign wr_accept  = armed & ~done & ~cs_n & ~wr_n & ~busy;
  assign drain_tick = armed & (div_cnt == DW'(DRAIN_DIV - 1));
  assign drain_pop  = drain_tick & ~buf_empty & ~done;
  assign rd_req     = keep_alive & done & ~cs_n & wr_n;
  assign cs_out_n   = ~done;

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n) begin
      acc_cnt <= '0;
      div_cnt <= '0;
    end else begin
      if (wr_accept) acc_cnt <= acc_cnt + 1'b1;
      if (!armed) div_cnt <= '0;
      else        div_cnt <= DW'(wrap_inc(int'(div_cnt), DRAIN_DIV));
    end
  end

  cfg_byte_fifo #(.DEPTH(BUF_DEPTH), .W(W)) u_buf (
    .clk   (cclk),
    .rst_n (prog_n),
    .push  (wr_accept),
    .wdata (din),
    .pop   (drain_pop),
    .rdata (buf_head),
    .full  (buf_full),
    .empty (buf_empty)
  );

  cfg_payload_store #(.P(PAYLOAD_BYTES), .W(W)) u_store (
    .clk        (cclk),
    .rst_n      (prog_n),
    .st_en      (drain_pop),
    .st_data    (buf_head),
    .rd_req     (rd_req),
    .done       (done),
    .last_store (last_store),
    .dout       (dout),
    .dout_vld   (dout_vld)
  );

  AST_ARM_ONLY_ON_INIT: assert property (@(posedge cclk) disable iff (!prog_n)
    (armed != $past(armed)) |-> $past(init_rise)); // R2
  AST_IDLE_UNARMED: assert property (@(posedge cclk) disable iff (!prog_n)
    !armed |-> !busy); // R3
  AST_ACCEPT_CAP: assert property (@(posedge cclk) disable iff (!prog_n)
    wr_accept |-> (acc_cnt < AW'(PAYLOAD_BYTES))); // R5
  AST_NO_READ_WITHOUT_KEEP: assert property (@(posedge cclk) disable iff (!prog_n)
    dout_vld |-> $past(keep_alive)); // R8
  AST_HANDOFF_DRIVEN: assert property (@(posedge cclk) disable iff (!prog_n)
    !$isunknown(cs_out_n)); // R7

endmodule

// File: tb/tb_cfg_byte_port.sv
module tb_cfg_byte_port;
  localparam int P = 8;
  localparam int N = 3;

  logic       cclk = 1'b0;
  logic       prog_n, init_rel, keep_alive, cs_n, wr_n;
  logic [2:0] mode_sel;
  logic [7:0] din;
  logic       busy, done, cs_out_n, dout_vld;
  logic [7:0] dout;

  cfg_byte_port #(.PAYLOAD_BYTES(P), .DRAIN_DIV(N), .BUF_DEPTH(4), .W(8)) dut (
    .cclk(cclk), .prog_n(prog_n), .init_rel(init_rel), .mode_sel(mode_sel),
    .keep_alive(keep_alive), .cs_n(cs_n), .wr_n(wr_n), .din(din),
    .busy(busy), .done(done), .cs_out_n(cs_out_n), .dout(dout), .dout_vld(dout_vld)
  );

  always #10 cclk = ~cclk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit         m_init_q, m_armed, m_done, m_vld;
  logic [7:0] q[$];
  int         m_acc, m_div, m_st, m_rp;
  logic [7:0] m_mem [P];
  logic [7:0] m_dout;

  function automatic bit m_busy();
    return m_armed && !m_done && (q.size() == 4 || m_acc == P);
  endfunction

  always @(posedge cclk or negedge prog_n) begin
    if (!prog_n) begin
      m_init_q = 0; m_armed = 0; m_done = 0; m_vld = 0; m_dout = 0;
      q.delete(); m_acc = 0; m_div = 0; m_st = 0; m_rp = 0;
    end else begin
      bit b, acc, tk, rd, rise;
      b    = m_busy();
      acc  = m_armed && !m_done && !cs_n && !wr_n && !b;
      tk   = m_armed && (m_div == N - 1);
      rd   = keep_alive && m_done && !cs_n && wr_n;
      rise = init_rel && !m_init_q;
      if (rd) begin
        m_dout = m_mem[m_rp]; m_vld = 1; m_rp = (m_rp + 1) % P;
      end else begin
        m_dout = 0; m_vld = 0; m_rp = 0;
      end
      if (tk && q.size() > 0 && !m_done) begin
        m_mem[m_st] = q.pop_front();
        m_st++;
        if (m_st == P) m_done = 1;
      end
      if (acc) begin q.push_back(din); m_acc++; end
      m_div = !m_armed ? 0 : ((m_div == N - 1) ? 0 : m_div + 1);
      if (rise) m_armed = (mode_sel == 3'b110);
      m_init_q = init_rel;
    end
  end

  // Compare on every falling edge, away from the active edge.
  always @(negedge cclk) begin
    chk(busy == m_busy(), "R5", "busy", busy, m_busy());
    chk(done == m_done, "R7", "done", done, m_done);
    chk(cs_out_n == !m_done, "R7", "cs_out_n", cs_out_n, !m_done);
    chk(dout_vld == m_vld, "R9", "dout_vld", dout_vld, m_vld);
    chk(dout == m_dout, "R9", "dout", dout, m_dout);
  end

  always @(posedge cclk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge cclk); #2;
  endtask

  task automatic idle_bus();
    cs_n = 1; wr_n = 1; din = 8'h00;
  endtask

  task automatic do_reset();
    idle_bus(); init_rel = 0; prog_n = 0;
    repeat (3) step();
    prog_n = 1;
    step();
  endtask

  task automatic arm(input logic [2:0] code);
    mode_sel = code; step();
    init_rel = 1; step(); step();
  endtask

  task automatic host_write(input logic [7:0] b);
    bit was_busy;
    cs_n = 0; wr_n = 0; din = b;
    do begin
      was_busy = busy;
      step();
    end while (was_busy);
    idle_bus();
  endtask

  task automatic noise();
    cs_n = 1; wr_n = 0; din = 8'hEE; step();   // R4: deselected write
    cs_n = 0; wr_n = 1; din = 8'hDD; step();   // R4: read strobe before done
    idle_bus();
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 300) begin step(); n++; end
  endtask

  logic [7:0] wl [P];

  initial begin
    int busy_seen;
    keep_alive = 0; mode_sel = 3'b000; init_rel = 0; idle_bus();
    prog_n = 0;
    repeat (2) step();
    // R1: reset state while prog_n low
    chk(busy == 0 && done == 0 && cs_out_n == 1 && dout_vld == 0 && dout == 0,
        "R1", "reset outputs", {busy, done, cs_out_n, dout_vld}, 4'b0010);
    prog_n = 1; step();
    chk(cs_out_n == 1 && done == 0, "R1", "after release", cs_out_n, 1);

    // R3: wrong mode code, port stays unarmed
    arm(3'b010);
    for (int i = 0; i < 10; i++) begin
      cs_n = 0; wr_n = 0; din = 8'(i); step();
      chk(busy == 0, "R3", "busy while unarmed", busy, 0);
    end
    idle_bus(); repeat (20) step();
    chk(done == 0, "R3", "done while unarmed", done, 0);
    // R2: code changed without a new init rise has no effect
    mode_sel = 3'b110;
    for (int i = 0; i < 10; i++) begin
      cs_n = 0; wr_n = 0; din = 8'(i); step();
    end
    idle_bus(); repeat (20) step();
    chk(done == 0, "R2", "no re-sample without rise", done, 0);

    // Write path without keep-alive
    do_reset();
    arm(3'b110);
    busy_seen = 0;
    for (int i = 0; i < P; i++) begin
      if (i < 2) noise();
      cs_n = 0; wr_n = 0; din = 8'h40 + 8'(i);
      while (busy) begin busy_seen++; step(); end
      step(); idle_bus();
    end
    // R5: back-to-back writes into a slow drain must raise busy
    chk(busy_seen > 0, "R5", "busy observed", busy_seen, 1);
    wait_done();
    chk(done == 1 && cs_out_n == 0, "R7", "hand-off", cs_out_n, 0);
    // R8: bus ignored after done with keep_alive=0
    cs_n = 0; wr_n = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(dout_vld == 0, "R8", "no readback", dout_vld, 0);
    end
    cs_n = 0; wr_n = 0; din = 8'h99; step();
    chk(busy == 0 && done == 1, "R8", "busy after done", busy, 0);
    idle_bus();

    // Readback with keep-alive
    do_reset();
    keep_alive = 1;
    arm(3'b110);
    for (int i = 0; i < P; i++) begin
      wl[i] = 8'hA0 ^ 8'(i * 7);
      host_write(wl[i]);
      if (i == 3) noise();
    end
    wait_done();
    chk(done == 1, "R7", "done with keep_alive", done, 1);
    for (int i = 0; i < 3; i++) host_write(8'h5A);   // R10: late writes
    cs_n = 0; wr_n = 1;
    for (int i = 0; i < P + 3; i++) begin
      step();
      chk(dout_vld == 1 && dout == wl[i % P], "R9", "readback order/wrap",
          dout, wl[i % P]);
      if (i < P) chk(dout == wl[i], "R10", "payload intact", dout, wl[i]);
    end
    cs_n = 1; step();
    chk(dout_vld == 0, "R9", "pause", dout_vld, 0);
    cs_n = 0;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(dout == wl[i], "R9", "restart at 0", dout, wl[i]);
    end
    idle_bus(); step();
    // R6: ordering of drained bytes is confirmed by the readback above
    chk(done == 1, "R6", "drain complete", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule